// File: doc/BRIEF.md
# Switch Table Indirect Access Controller

This block lets a host reach three internal lookup tables of an Ethernet switch through a small window of four 32-bit registers. The tables are a VLAN table, a static MAC table and a dynamic MAC table. The host never addresses a table entry directly. It writes a command word that names the operation, the table and the entry index. Entry contents pass through a 69-bit data window made of three registers.

For a write, the host first fills the data registers and then issues the command, which copies the window into the chosen entry. For a read, the host issues the command, and the block places the entry into the window.

Static and VLAN reads complete in one cycle. A dynamic-table read first shows a not-ready flag for a fixed number of cycles, then loads the entry together with the table's occupancy: an empty flag and the count of valid entries minus one. Address learning is not part of this block. A separate learn port fills and clears the dynamic table.

Top module: `swtab_access`

## Requirements
- R1: Register addresses are 0 for the command, 1 for the data low word (bits 31:0), 2 for the data middle word (bits 63:32) and 3 for the data high register (bits 68:64 in read bits 4:0). Command bit 12 set means read, bits 11:10 select the table (0 static MAC, 1 VLAN, 2 dynamic MAC, 3 MIB counters), and bits 9:0 are the entry index. Address 0 and bits 31:5 of address 3 read as zero. After reset all data registers and all table entries are zero.
- R2: A write command to the static or VLAN table stores an entry derived from the current data window, and it leaves the data registers unchanged. A read command loads the entry into the window in the cycle after the command is accepted.
- R3: The VLAN entry fields are VLAN ID at bits 11:0, filter ID at 15:12, member ports at 20:16 and valid at 21. On a write the valid bit is set exactly when the VLAN ID is nonzero, and the written bit 21 is ignored. A write with VLAN ID 0 leaves the entry all zero.
- R4: The static entry fields are MAC at bits 47:0, forward ports at 52:48, valid at 53, spanning-tree override at 54, use-FID at 55 and FID at 59:56, with the same layout on read and on write. Window bits 68:60 are not stored. A write with bit 53 clear leaves the entry all zero.
- R5: A read of a static or VLAN index at or beyond the table depth returns all zeros. A write to such an index changes no entry, including the entry whose low index bits match.
- R6: A read with the MIB selection returns an all-zero window. Write commands with the MIB or dynamic selection change no table.
- R7: After a dynamic read command, the window holds only bit 55 (the not-ready flag, middle-word bit 23) for NR_CYCLES cycles. The entry is then loaded with bit 55 clear.
- R8: The dynamic entry fields are MAC at bits 47:0, FID at 51:48, source port at 54:52 and age at 57:56. For an index beyond the table depth, or an entry that is not present, these fields read as zero.
- R9: Bits 67:58 of a dynamic read hold the number of present entries minus one, or 0 when there are none. Bit 68 is set exactly when no entry is present.
- R10: While the not-ready flag is set, host writes to any register, including new commands, are ignored.
- R11: A learn-port write at an index below the dynamic depth stores the fields and marks the entry present when learn_valid is 1, or removes it when learn_valid is 0. A learn-port write at a larger index is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected register contents |
| learn_we | input | 1 | Learn-port write strobe |
| learn_idx | input | 10 | Dynamic table entry index |
| learn_valid | input | 1 | 1 stores the entry, 0 removes it |
| learn_mac | input | 48 | MAC address of the entry |
| learn_fid | input | 4 | Filter ID of the entry |
| learn_port | input | 3 | Source port of the entry |
| learn_age | input | 2 | Age stamp of the entry |

## Verification
Directed cases cover the following:
- VLAN writes with a zero and a nonzero VLAN ID, which separate the forced valid rule from a plain copy of bit 21.
- Static writes with the valid bit set and clear, carrying junk in bits 68:60.
- Indices just past each table depth, which expose index truncation aliasing onto a real entry.
- An empty dynamic table against a partly filled one, which separates the empty flag from the count-minus-one field.
- A dynamic read interrupted by data and command writes, cycle by cycle through the not-ready window.

Random mixes of writes, reads and learn-port updates, with indices spread over and beyond each depth, are then compared with table models kept in the bench.

// File: rtl/swtab_pkg.sv
`timescale 1ns/1ps
package swtab_pkg;

  localparam int IDX_W    = 10;  // entry index field width
  localparam int DW       = 69;  // data window width
  localparam int VLAN_W   = 22;  // stored VLAN entry
  localparam int SMAC_W   = 60;  // stored static entry
  localparam int DENT_W   = 57;  // stored dynamic entry {age,port,fid,mac}
  localparam int RD_BIT   = 12;
  localparam int SEL_LSB  = 10;

  typedef enum logic [1:0] {
    SEL_SMAC = 2'd0,
    SEL_VLAN = 2'd1,
    SEL_DYN  = 2'd2,
    SEL_MIB  = 2'd3
  } tbl_sel_e;

  typedef logic [DW-1:0] win_t;

  // VLAN commit: valid is forced from the VLAN ID (R3)
  function automatic logic [VLAN_W-1:0] vlan_commit(win_t w);
    if (w[11:0] != 12'd0) vlan_commit = {1'b1, w[20:0]};
    else                  vlan_commit = '0;
  endfunction

  // Static commit: an entry written without its valid bit is cleared (R4)
  function automatic logic [SMAC_W-1:0] smac_commit(win_t w);
    if (w[53]) smac_commit = w[SMAC_W-1:0];
    else       smac_commit = '0;
  endfunction

  // Dynamic read word: status fields plus the entry when present (R8, R9)
  function automatic win_t dyn_word(logic [10:0] n, logic hit, logic [DENT_W-1:0] e);
    logic [9:0]        nm1;
    logic [DENT_W-1:0] f;
    nm1 = (n == 11'd0) ? 10'd0 : 10'(n - 11'd1);
    f   = hit ? e : '0;
    dyn_word = {(n == 11'd0), nm1, f[56:55], 1'b0, f[54:0]};
  endfunction

endpackage

// File: rtl/swtab_store.sv
`timescale 1ns/1ps
module swtab_store #(
  parameter int DEPTH = 16,
  parameter int W     = 22,
  parameter int IW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] ent [DEPTH];
  logic         wr_in_rng;
  logic         rd_in_rng;

  assign wr_in_rng = wr_idx < IW'(DEPTH);   // R5
  assign rd_in_rng = rd_idx < IW'(DEPTH);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q <= '0;
      else if (wr_en && wr_in_rng && wr_idx[AW-1:0] == AW'(g))
        ent_q <= wr_data;
    end
    assign ent[g] = ent_q;
  end

  assign rd_data = rd_in_rng ? ent[rd_idx[AW-1:0]] : '0;

endmodule

// File: rtl/swtab_dyn.sv
`timescale 1ns/1ps
module swtab_dyn #(
  parameter int DEPTH = 16,
  parameter int IW    = 10,
  parameter int EW    = 57
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lw_en,
  input  logic [IW-1:0] lw_idx,
  input  logic          lw_valid,
  input  logic [EW-1:0] lw_entry,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_hit,
  output logic [EW-1:0] rd_entry,
  output logic [10:0]   valid_cnt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [EW-1:0] ent [DEPTH];
  logic [DEPTH-1:0] vld;
  logic lw_in_rng;
  logic rd_in_rng;

  assign lw_in_rng = lw_idx < IW'(DEPTH);   // R11
  assign rd_in_rng = rd_idx < IW'(DEPTH);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [EW-1:0] ent_q;
    logic          vld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
        vld_q <= 1'b0;
      end else if (lw_en && lw_in_rng && lw_idx[AW-1:0] == AW'(g)) begin
        ent_q <= lw_valid ? lw_entry : '0;
        vld_q <= lw_valid;
      end
    end
    assign ent[g] = ent_q;
    assign vld[g] = vld_q;
  end

  always_comb begin
    valid_cnt = '0;
    for (int i = 0; i < DEPTH; i++) valid_cnt = valid_cnt + 11'(vld[i]);
  end

  assign rd_hit   = rd_in_rng && vld[rd_idx[AW-1:0]];
  assign rd_entry = rd_in_rng ? ent[rd_idx[AW-1:0]] : '0;

endmodule

// File: rtl/swtab_access.sv
`timescale 1ns/1ps
module swtab_access #(
  parameter int VLAN_DEPTH = 16,
  parameter int SMAC_DEPTH = 8,
  parameter int DYN_DEPTH  = 16,
  parameter int NR_CYCLES  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        learn_we,
  input  logic [9:0]  learn_idx,
  input  logic        learn_valid,
  input  logic [47:0] learn_mac,
  input  logic [3:0]  learn_fid,
  input  logic [2:0]  learn_port,
  input  logic [1:0]  learn_age
);
  import swtab_pkg::*;

  localparam int NR_W = $clog2(NR_CYCLES + 1);

  logic [31:0]       dat_lo, dat_mid;
  logic [4:0]        dat_hi;
  logic [NR_W-1:0]   nr_cnt;
  logic [IDX_W-1:0]  pend_idx;
  win_t              win;

  // named events
  logic              busy, cmd_acc, cmd_rd, dyn_load;
  tbl_sel_e          cmd_sel;
  logic [IDX_W-1:0]  cmd_idx;
  logic              vlan_we, smac_we;

  logic [VLAN_W-1:0] vlan_rd;
  logic [SMAC_W-1:0] smac_rd;
  logic              dyn_hit;
  logic [DENT_W-1:0] dyn_entry;
  logic [10:0]       dyn_cnt;

  assign win      = {dat_hi, dat_mid, dat_lo};
  assign busy     = nr_cnt != '0;
  assign dyn_load = busy && (nr_cnt == NR_W'(1));
  assign cmd_acc  = host_we && (host_addr == 2'd0) && !busy;   // R10
  assign cmd_rd   = host_wdata[RD_BIT];
  assign cmd_sel  = tbl_sel_e'(host_wdata[SEL_LSB +: 2]);
  assign cmd_idx  = host_wdata[IDX_W-1:0];
  assign vlan_we  = cmd_acc && !cmd_rd && (cmd_sel == SEL_VLAN);
  assign smac_we  = cmd_acc && !cmd_rd && (cmd_sel == SEL_SMAC);

  swtab_store #(.DEPTH(VLAN_DEPTH), .W(VLAN_W), .IW(IDX_W)) u_vlan (
    .clk(clk), .rst_n(rst_n),
    .wr_en(vlan_we), .wr_idx(cmd_idx), .wr_data(vlan_commit(win)),
    .rd_idx(cmd_idx), .rd_data(vlan_rd)
  );

  swtab_store #(.DEPTH(SMAC_DEPTH), .W(SMAC_W), .IW(IDX_W)) u_smac (
    .clk(clk), .rst_n(rst_n),
    .wr_en(smac_we), .wr_idx(cmd_idx), .wr_data(smac_commit(win)),
    .rd_idx(cmd_idx), .rd_data(smac_rd)
  );

  swtab_dyn #(.DEPTH(DYN_DEPTH), .IW(IDX_W), .EW(DENT_W)) u_dyn (
    .clk(clk), .rst_n(rst_n),
    .lw_en(learn_we), .lw_idx(learn_idx), .lw_valid(learn_valid),
    .lw_entry({learn_age, learn_port, learn_fid, learn_mac}),
    .rd_idx(pend_idx), .rd_hit(dyn_hit), .rd_entry(dyn_entry),
    .valid_cnt(dyn_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {dat_hi, dat_mid, dat_lo} <= '0;
      nr_cnt   <= '0;
      pend_idx <= '0;
    end else if (dyn_load) begin                       // R7 end of window
      {dat_hi, dat_mid, dat_lo} <= dyn_word(dyn_cnt, dyn_hit, dyn_entry);
      nr_cnt <= '0;
    end else if (busy) begin                           // R10 host frozen out
      nr_cnt <= nr_cnt - NR_W'(1);
    end else if (host_we) begin
      unique case (host_addr)
        2'd1: dat_lo  <= host_wdata;
        2'd2: dat_mid <= host_wdata;
        2'd3: dat_hi  <= host_wdata[4:0];
        default: begin
          if (cmd_rd) begin
            unique case (cmd_sel)
              SEL_SMAC: {dat_hi, dat_mid, dat_lo} <= DW'(smac_rd);
              SEL_VLAN: {dat_hi, dat_mid, dat_lo} <= DW'(vlan_rd);
              SEL_DYN: begin
                {dat_hi, dat_mid, dat_lo} <= DW'(1) << 55;
                nr_cnt   <= NR_W'(NR_CYCLES);
                pend_idx <= cmd_idx;
              end
              default:  {dat_hi, dat_mid, dat_lo} <= '0;  // R6 MIB
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    unique case (host_addr)
      2'd1:    host_rdata = dat_lo;
      2'd2:    host_rdata = dat_mid;
      2'd3:    host_rdata = {27'd0, dat_hi};
      default: host_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/swtab_access_chk.sv
`timescale 1ns/1ps
module swtab_access_chk #(
  parameter int NR_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        dyn_load,
  input logic        cmd_acc,
  input logic [1:0]  host_addr,
  input logic [31:0] host_wdata,
  input logic [31:0] host_rdata,
  input logic [31:0] dat_lo,
  input logic [31:0] dat_mid,
  input logic [4:0]  dat_hi
);
  logic [15:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else        run <= busy ? run + 16'd1 : 16'd0;
  end

  AST_HI_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr == 2'd3 |-> host_rdata[31:5] == 27'd0); // R1

  AST_VLAN_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc && host_wdata[12] && host_wdata[11:10] == 2'd1 |=>
      dat_lo[21] == (dat_lo[11:0] != 12'd0) && dat_lo[31:22] == 10'd0 &&
      dat_mid == 32'd0 && dat_hi == 5'd0); // R3

  AST_SMAC_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc && host_wdata[12] && host_wdata[11:10] == 2'd0 |=>
      dat_hi == 5'd0 && dat_mid[31:28] == 4'd0 &&
      (dat_mid[21] || (dat_mid == 32'd0 && dat_lo == 32'd0))); // R4

  AST_MIB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc && host_wdata[12] && host_wdata[11:10] == 2'd3 |=>
      dat_lo == 32'd0 && dat_mid == 32'd0 && dat_hi == 5'd0); // R6

  AST_NR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> dat_mid == 32'h0080_0000 && dat_lo == 32'd0 && dat_hi == 5'd0); // R7

  AST_NR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 16'(NR_CYCLES)); // R7

  AST_LOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    dyn_load |=> !busy && !dat_mid[23]); // R7

  AST_EMPTY_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    dyn_load |=> !dat_hi[4] ||
      ({dat_hi[3:0], dat_mid} == 36'd0 && dat_lo == 32'd0)); // R9

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !dyn_load |=> $stable(dat_lo) && $stable(dat_mid) && $stable(dat_hi)); // R10

endmodule

bind swtab_access swtab_access_chk #(.NR_CYCLES(NR_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dyn_load(dyn_load),
  .cmd_acc(cmd_acc), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .dat_lo(dat_lo), .dat_mid(dat_mid), .dat_hi(dat_hi)
);

// File: tb/swtab_access_tb_top.sv
`timescale 1ns/1ps
module swtab_access_tb_top;
  localparam int NR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = 32'd0;
  logic [31:0] host_rdata;
  logic        learn_we = 1'b0;
  logic [9:0]  learn_idx = 10'd0;
  logic        learn_valid = 1'b0;
  logic [47:0] learn_mac = 48'd0;
  logic [3:0]  learn_fid = 4'd0;
  logic [2:0]  learn_port = 3'd0;
  logic [1:0]  learn_age = 2'd0;

  int nchk = 0;
  int nfail = 0;

  // bench table models
  logic [21:0] m_vlan [16];
  logic [59:0] m_smac [8];
  logic        m_dv   [16];
  logic [47:0] m_dmac [16];
  logic [3:0]  m_dfid [16];
  logic [2:0]  m_dport[16];
  logic [1:0]  m_dage [16];

  always #4 clk = ~clk;

  swtab_access #(.NR_CYCLES(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .learn_we(learn_we), .learn_idx(learn_idx), .learn_valid(learn_valid),
    .learn_mac(learn_mac), .learn_fid(learn_fid), .learn_port(learn_port),
    .learn_age(learn_age)
  );

  task automatic check(input string req, input logic [68:0] act, input logic [68:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk);
    #1 host_we = 1'b0;
  endtask

  task automatic rd_word(output logic [68:0] w);
    host_addr = 2'd1; #0.5 w[31:0]  = host_rdata;
    host_addr = 2'd2; #0.5 w[63:32] = host_rdata;
    host_addr = 2'd3; #0.5 w[68:64] = host_rdata[4:0];
  endtask

  task automatic load(input logic [68:0] w);
    hw(2'd1, w[31:0]); hw(2'd2, w[63:32]); hw(2'd3, {27'd0, w[68:64]});
  endtask

  task automatic cmd(input logic rd, input logic [1:0] sel, input logic [9:0] idx);
    hw(2'd0, {19'd0, rd, sel, idx});
  endtask

  task automatic learn(input logic [9:0] idx, input logic v, input logic [47:0] mac,
                       input logic [3:0] fid, input logic [2:0] port, input logic [1:0] age);
    @(negedge clk);
    learn_we = 1'b1; learn_idx = idx; learn_valid = v; learn_mac = mac;
    learn_fid = fid; learn_port = port; learn_age = age;
    @(posedge clk);
    #1 learn_we = 1'b0;
    if (idx < 16) begin
      m_dv[idx] = v;
      m_dmac[idx] = v ? mac : 48'd0; m_dfid[idx] = v ? fid : 4'd0;
      m_dport[idx] = v ? port : 3'd0; m_dage[idx] = v ? age : 2'd0;
    end
  endtask

  // expected-value functions, written from the requirements
  function automatic logic [21:0] vlan_store_exp(logic [68:0] w);
    logic [21:0] e;
    e = 22'd0;
    if (|w[11:0]) begin
      e[11:0] = w[11:0]; e[15:12] = w[15:12]; e[20:16] = w[20:16]; e[21] = 1'b1;
    end
    return e;
  endfunction

  function automatic logic [59:0] smac_store_exp(logic [68:0] w);
    return w[53] ? w[59:0] : 60'd0;
  endfunction

  function automatic logic [68:0] vlan_rd_exp(int idx);
    return (idx < 16) ? {47'd0, m_vlan[idx]} : 69'd0;
  endfunction

  function automatic logic [68:0] smac_rd_exp(int idx);
    return (idx < 8) ? {9'd0, m_smac[idx]} : 69'd0;
  endfunction

  function automatic logic [68:0] dyn_rd_exp(int idx);
    logic [68:0] w;
    int n;
    n = 0;
    for (int i = 0; i < 16; i++) if (m_dv[i]) n++;
    w = 69'd0;
    w[68] = (n == 0);
    if (n > 0) w[67:58] = 10'(n - 1);
    if (idx < 16 && m_dv[idx]) begin
      w[47:0] = m_dmac[idx]; w[51:48] = m_dfid[idx];
      w[54:52] = m_dport[idx]; w[57:56] = m_dage[idx];
    end
    return w;
  endfunction

  function automatic logic [68:0] rnd69();
    logic [95:0] r;
    r = {$urandom, $urandom, $urandom};
    return r[68:0];
  endfunction

  task automatic dyn_read(input int idx, input bit win_chk, input string req);
    logic [68:0] w;
    cmd(1'b1, 2'd2, 10'(idx));
    for (int k = 0; k < NR; k++) begin
      rd_word(w);
      if (win_chk) check("R7 not-ready window", w, 69'd1 << 55);
      @(posedge clk); #1;
    end
    rd_word(w);
    check(req, w, dyn_rd_exp(idx));
  endtask

  task automatic vlan_write(input int idx, input logic [68:0] w);
    load(w);
    cmd(1'b0, 2'd1, 10'(idx));
    if (idx < 16) m_vlan[idx] = vlan_store_exp(w);
  endtask

  task automatic smac_write(input int idx, input logic [68:0] w);
    load(w);
    cmd(1'b0, 2'd0, 10'(idx));
    if (idx < 8) m_smac[idx] = smac_store_exp(w);
  endtask

  task automatic vlan_read(input int idx, input string req);
    logic [68:0] w;
    cmd(1'b1, 2'd1, 10'(idx));
    rd_word(w);
    check(req, w, vlan_rd_exp(idx));
  endtask

  task automatic smac_read(input int idx, input string req);
    logic [68:0] w;
    cmd(1'b1, 2'd0, 10'(idx));
    rd_word(w);
    check(req, w, smac_rd_exp(idx));
  endtask

  initial begin : watchdog
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [68:0] w, d;
    void'($urandom(32'd8675309));
    for (int i = 0; i < 16; i++) begin
      m_vlan[i] = '0; m_dv[i] = 1'b0; m_dmac[i] = '0;
      m_dfid[i] = '0; m_dport[i] = '0; m_dage[i] = '0;
    end
    for (int i = 0; i < 8; i++) m_smac[i] = '0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state and register map
    rd_word(w);
    check("R1 reset window", w, 69'd0);
    host_addr = 2'd0; #0.5 check("R1 cmd addr reads zero", {37'd0, host_rdata}, 69'd0);
    hw(2'd3, 32'hFFFF_FFFF);
    host_addr = 2'd3; #0.5 check("R1 high pad", {37'd0, host_rdata}, 69'h1F);
    vlan_read(0, "R1 reset VLAN entry");
    smac_read(7, "R1 reset static entry");
    dyn_read(0, 1'b0, "R9 empty table");

    // R2/R3 VLAN commit, valid forced by VID, bit 21 ignored
    d = 69'd0; d[11:0] = 12'h123; d[15:12] = 4'h9; d[20:16] = 5'h15; d[21] = 1'b0;
    d[68:22] = '1;
    vlan_write(3, d);
    rd_word(w);
    check("R2 data kept after write", w, d);
    vlan_read(3, "R3 VLAN valid from nonzero VID");
    d = 69'd0; d[15:12] = 4'h5; d[20:16] = 5'h1F; d[21] = 1'b1;
    vlan_write(5, d);
    vlan_read(5, "R3 VID zero leaves entry clear");

    // R4 static layout, junk above bit 59, invalid write clears
    d = rnd69(); d[53] = 1'b1; d[68:60] = 9'h1AB;
    smac_write(7, d);
    smac_read(7, "R4 static entry with valid");
    d = rnd69(); d[53] = 1'b0;
    smac_write(2, d);
    smac_read(2, "R4 static write without valid");

    // R5 out-of-range indices: aliasing writes must not land
    vlan_write(19, rnd69() | 69'h1);
    vlan_read(3, "R5 VLAN alias write ignored");
    vlan_read(16, "R5 VLAN read past depth");
    d = rnd69(); d[53] = 1'b1;
    smac_write(15, d);
    smac_read(7, "R5 static alias write ignored");
    smac_read(8, "R5 static read past depth");

    // R6 MIB selection and dynamic writes
    load(rnd69() | 69'h1);
    cmd(1'b1, 2'd3, 10'd3);
    rd_word(w);
    check("R6 MIB read zero", w, 69'd0);
    load(rnd69() | 69'h1);
    cmd(1'b0, 2'd3, 10'd3);
    vlan_read(3, "R6 MIB write leaves VLAN");
    smac_read(7, "R6 MIB write leaves static");
    load(rnd69() | 69'h1);
    cmd(1'b0, 2'd2, 10'd1);
    dyn_read(1, 1'b0, "R6 dynamic host write ignored");

    // R11 learn port, R8/R9 formats, R7 window
    learn(10'd0, 1'b1, 48'hA1B2_C3D4_E5F6, 4'hC, 3'd5, 2'd2);
    learn(10'd15, 1'b1, 48'h0102_0304_0506, 4'h3, 3'd7, 2'd3);
    learn(10'd16, 1'b1, 48'hFFFF_FFFF_FFFF, 4'hF, 3'd7, 2'd3);
    dyn_read(0, 1'b1, "R11 R8 present entry and count");
    dyn_read(20, 1'b0, "R8 past depth fields zero");
    dyn_read(4, 1'b0, "R8 absent entry fields zero");
    learn(10'd15, 1'b0, 48'd0, 4'd0, 3'd0, 2'd0);
    dyn_read(15, 1'b0, "R11 removed entry");
    learn(10'd0, 1'b0, 48'd0, 4'd0, 3'd0, 2'd0);
    dyn_read(0, 1'b0, "R9 empty again after removals");

    // R10 writes during the not-ready window
    learn(10'd6, 1'b1, 48'h0000_1111_2222, 4'h1, 3'd2, 2'd1);
    cmd(1'b1, 2'd2, 10'd6);
    hw(2'd1, 32'hDEAD_BEEF);
    hw(2'd0, {19'd0, 1'b0, 2'd1, 10'd3});
    @(posedge clk); @(posedge clk); #1;
    rd_word(w);
    check("R10 data write ignored while busy", w, dyn_rd_exp(6));
    vlan_read(3, "R10 command ignored while busy");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op, idx;
      op = $urandom % 6;
      case (op)
        0: begin
          idx = $urandom % 20; d = rnd69();
          if ($urandom % 4 == 0) d[11:0] = 12'd0;
          vlan_write(idx, d);
        end
        1: begin
          idx = $urandom % 10; d = rnd69(); d[53] = ($urandom % 4) != 0;
          smac_write(idx, d);
        end
        2: vlan_read($urandom % 20, "R3 R5 random VLAN read");
        3: smac_read($urandom % 10, "R4 R5 random static read");
        4: learn(10'($urandom % 18), ($urandom % 4) != 0, {$urandom, $urandom},
                 4'($urandom), 3'($urandom), 2'($urandom));
        default: dyn_read($urandom % 20, 1'b0, "R8 R9 random dynamic read");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule